// File: doc/BRIEF.md
# RTC Drift Trim and Clock Output Selector

This block sits between a real-time clock's raw input clock and its time-keeping counters. It divides the raw clock into a once-per-second tick with a sub-second prescaler. To correct crystal drift, it preloads that prescaler with a signed offset at every one-minute boundary. The offset is the 8-bit trim code times four. A positive code shortens the minute by that many raw clock pulses and a negative code lengthens it, so the range runs from +508 to -512 pulses per minute.

The block also holds one configuration word: the trim code, a run enable, a pin-enable, a pin source select and a read-only status flag. It drives an external clock pin from a chosen timing signal. The configuration word is cleared only by power-on reset. A system reset restarts the prescaler and leaves the configuration untouched. The run enable changes only when the write-unlock input is high. The raw clock is presented as a one-cycle `rtc_pulse` in the system clock domain, one strobe per raw edge.

Top module: `rtc_trim_out`

## Requirements
- R1: After power-on reset, `cfg_rdata` reads 0x0000, and `sec_tick` and `rtc_pin` are low.
- R2: While the run enable is 1, `sec_tick` pulses high for one cycle, one cycle after every PRESCALE-th counted `rtc_pulse`. The prescaler counts 0 to PRESCALE-1 and wraps to 0.
- R3: When `min_strobe` is high while enabled, the prescaler loads 4 x (trim code as two's complement), and any `rtc_pulse` in that cycle is not counted. If the same cycle holds the wrap pulse, that wrap tick is still issued.
- R4: After a `min_strobe` that coincides with a wrap, the next 8 ticks take 8 x PRESCALE - 4 x code pulses. The codes give 0x00: no change, 0x01: 4 fewer, 0x7F: 508 fewer, 0xFF: 4 more, 0x80: 512 more.
- R5: With the run enable at 0, the prescaler holds its value, `rtc_pulse` and `min_strobe` are ignored, and no tick is issued.
- R6: Configuration bit 15 is the run enable. A write with byte enable 1 (`wr_be[1]`) changes it only if `wr_unlock` is 1 in that cycle.
- R7: Configuration word layout: bit 15 enable, bit 14 pin enable, bits 13:12 pin source, bit 11 status, bits 10:8 unimplemented (read 0, writes ignored), bits 7:0 trim code.
- R8: Status bit 11 is set one cycle after each `sec_tick` pulse. It is cleared by a write with `wr_sel`=1 and `wr_be[0]`=1, and the clear wins if both happen in one cycle. Configuration writes never change it.
- R9: `rtc_pin` is registered, one cycle late. The pin source codes are 00 for `alarm_pulse`, 01 for `sec_clk`, 10 for `rtc_pulse`, and 11 for constant low.
- R10: With pin enable (bit 14) at 0, `rtc_pin` is low one cycle later and stays low.
- R11: `sys_rst_n` low clears the prescaler, `sec_tick` and `rtc_pin`, and leaves the configuration word unchanged.
- R12: A write with `wr_sel`=0 updates bits 7:0 only when `wr_be[0]` is set. It updates bits 15:12 only when `wr_be[1]` is set, with bit 15 further gated by R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous active low |
| sys_rst_n | input | 1 | System reset, asynchronous active low, prescaler only |
| rtc_pulse | input | 1 | One-cycle strobe per raw RTC clock edge |
| min_strobe | input | 1 | One-minute boundary strobe |
| sec_clk | input | 1 | Seconds clock from the time counters |
| alarm_pulse | input | 1 | Alarm pulse from the alarm logic |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0: configuration word, 1: minutes/seconds word |
| wr_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| wr_data | input | 16 | Write data |
| wr_unlock | input | 1 | Write unlock for the run enable |
| cfg_rdata | output | 16 | Configuration word readback |
| sec_tick | output | 1 | Corrected once-per-second tick |
| rtc_pin | output | 1 | External clock output pin |

## Verification
Two collisions matter here. The first is a minute boundary landing on the very pulse that wraps the prescaler. The bench waits until its own model shows the last count, then drives `min_strobe` together with that pulse. It expects both the wrap tick and the trim preload, and measures the pulses up to the eighth later tick for each of five trim codes. The second collision sets and clears the status flag in one cycle: a write to the minutes/seconds low byte is issued in the cycle `sec_tick` is high, and bit 11 must read 0 afterward.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  localparam int CAL_W    = 8;
  localparam int STEP_SH  = 2;   // each trim count is worth 4 pulses
  localparam int WORD_W   = 16;

  typedef enum logic [1:0] {
    PIN_ALARM = 2'b00,
    PIN_SEC   = 2'b01,
    PIN_RAW   = 2'b10,
    PIN_OFF   = 2'b11
  } pin_src_e;

  typedef struct packed {
    logic             run;
    logic             pin_en;
    pin_src_e         src;
    logic             stat;
    logic [CAL_W-1:0] trim;
  } cfg_t;

  // writable high-byte bits: run, pin_en, src; status excluded
  localparam logic [7:0] HI_WMASK = 8'b1111_0000;

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs
  import rtc_trim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [1:0]        wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_unlock,
  input  logic              tick_i,
  output cfg_t              cfg_o,
  output logic [WORD_W-1:0] rd_o
);
  cfg_t              cur_q, nxt;
  logic              cfg_wr, ms_wr, upd;
  logic [WORD_W-1:0] wmask, merged;

  assign rd_o = {cur_q.run, cur_q.pin_en, cur_q.src, cur_q.stat, 3'b000, cur_q.trim};

  always_comb begin
    cfg_wr = wr_en && !wr_sel;
    ms_wr  = wr_en &&  wr_sel && wr_be[0];
    wmask  = {wr_be[1] ? HI_WMASK : 8'h00, wr_be[0] ? 8'hFF : 8'h00};
    if (!wr_unlock) wmask[15] = 1'b0;
    merged = (rd_o & ~wmask) | (wr_data & wmask);
    nxt    = cur_q;
    if (cfg_wr) begin
      nxt.run    = merged[15];
      nxt.pin_en = merged[14];
      nxt.src    = pin_src_e'(merged[13:12]);
      nxt.trim   = merged[CAL_W-1:0];
    end
    if (tick_i) nxt.stat = 1'b1;
    if (ms_wr)  nxt.stat = 1'b0;
    upd = cfg_wr || ms_wr || tick_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cur_q <= '0;
    else if (upd) cur_q <= nxt;
  end

  assign cfg_o = cur_q;

  AST_RUN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_be[1] && !wr_unlock) |=> (cur_q.run == $past(cur_q.run))); // R6

  AST_STAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_be[0]) |=> !cur_q.stat); // R8

  AST_UNIMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o[10:8] == 3'b000); // R7
endmodule

// File: rtl/rtc_trim_presc.sv
module rtc_trim_presc
  import rtc_trim_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rtc_pulse,
  input  logic             min_strobe,
  input  logic [CAL_W-1:0] trim,
  output logic             tick_o
);
  localparam int CW_A   = $clog2(PRESCALE) + 2;
  localparam int CW_B   = CAL_W + STEP_SH + 1;
  localparam int CW     = (CW_A > CW_B) ? CW_A : CW_B;
  localparam int LAST_I = PRESCALE - 1;

  logic signed [CW-1:0] cnt_q, cnt_d, load_v;
  logic                 wrap, cnt_ce, tick_q;

  always_comb begin
    load_v = {{(CW-CAL_W){trim[CAL_W-1]}}, trim} << STEP_SH;
    wrap   = run && rtc_pulse && (cnt_q == CW'(LAST_I));
    cnt_ce = run && (min_strobe || rtc_pulse);
    if (min_strobe)  cnt_d = load_v;
    else if (wrap)   cnt_d = '0;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= wrap;
  end

  assign tick_o = tick_q;

  AST_TICK_HAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(rtc_pulse && run)); // R2

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cnt_q) && !tick_q)); // R5

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_I); // R3
endmodule

// File: rtl/rtc_pin_mux.sv
module rtc_pin_mux
  import rtc_trim_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_en,
  input  pin_src_e src,
  input  logic     alarm,
  input  logic     sec_clk,
  input  logic     raw,
  output logic     pin_o
);
  logic sel_v, pin_q;

  always_comb begin
    unique case (src)
      PIN_ALARM: sel_v = alarm;
      PIN_SEC:   sel_v = sec_clk;
      PIN_RAW:   sel_v = raw;
      default:   sel_v = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_en && sel_v;
  end

  assign pin_o = pin_q;

  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |=> !pin_q); // R10

  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (src == PIN_OFF) |=> !pin_q); // R9
endmodule

// File: rtl/rtc_trim_out.sv
module rtc_trim_out
  import rtc_trim_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic        rtc_pulse,
  input  logic        min_strobe,
  input  logic        sec_clk,
  input  logic        alarm_pulse,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [1:0]  wr_be,
  input  logic [15:0] wr_data,
  input  logic        wr_unlock,
  output logic [15:0] cfg_rdata,
  output logic        sec_tick,
  output logic        rtc_pin
);
  logic por_s_n, sys_s_n, core_rst_n;
  cfg_t cfg;

  rtc_rst_sync u_por_sync (.clk(clk), .arst_n(por_n),     .srst_n(por_s_n));
  rtc_rst_sync u_sys_sync (.clk(clk), .arst_n(sys_rst_n), .srst_n(sys_s_n));

  assign core_rst_n = por_s_n && sys_s_n;

  rtc_trim_regs u_regs (
    .clk(clk), .rst_n(por_s_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
    .wr_data(wr_data), .wr_unlock(wr_unlock), .tick_i(sec_tick),
    .cfg_o(cfg), .rd_o(cfg_rdata)
  );

  rtc_trim_presc #(.PRESCALE(PRESCALE)) u_presc (
    .clk(clk), .rst_n(core_rst_n), .run(cfg.run), .rtc_pulse(rtc_pulse),
    .min_strobe(min_strobe), .trim(cfg.trim), .tick_o(sec_tick)
  );

  rtc_pin_mux u_pin (
    .clk(clk), .rst_n(core_rst_n), .pin_en(cfg.pin_en), .src(cfg.src),
    .alarm(alarm_pulse), .sec_clk(sec_clk), .raw(rtc_pulse), .pin_o(rtc_pin)
  );
endmodule

// File: tb/sim_rtc_trim_out.sv
module sim_rtc_trim_out;
  localparam int P = 512;

  logic clk = 1'b0;
  logic por_n, sys_rst_n, rtc_pulse, min_strobe, sec_clk, alarm_pulse;
  logic wr_en, wr_sel, wr_unlock;
  logic [1:0] wr_be;
  logic [15:0] wr_data;
  logic [15:0] cfg_rdata;
  logic sec_tick, rtc_pin;

  always #2 clk = ~clk;

  rtc_trim_out #(.PRESCALE(P)) u0 (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .rtc_pulse(rtc_pulse),
    .min_strobe(min_strobe), .sec_clk(sec_clk), .alarm_pulse(alarm_pulse),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be), .wr_data(wr_data),
    .wr_unlock(wr_unlock), .cfg_rdata(cfg_rdata), .sec_tick(sec_tick), .rtc_pin(rtc_pin)
  );

  int n_vec = 0, n_bad = 0;
  bit mdl_run = 0, chk_on = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_run, m_pen, m_stat, m_tick, m_pin;
  bit [1:0] m_src;
  bit [7:0] m_cal;
  int m_cnt;
  int sec_phase = 0;

  function automatic logic [15:0] exp_word();
    return {m_run, m_pen, m_src, m_stat, 3'b000, m_cal};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (mdl_run) begin
      bit w, p;
      bit n_stat;
      int n_cnt;
      w = m_run && rtc_pulse && (m_cnt == P - 1);
      if (m_run && min_strobe)      n_cnt = 4 * int'($signed(m_cal));
      else if (w)                   n_cnt = 0;
      else if (m_run && rtc_pulse)  n_cnt = m_cnt + 1;
      else                          n_cnt = m_cnt;
      case (m_src)
        2'd0: p = alarm_pulse;
        2'd1: p = sec_clk;
        2'd2: p = rtc_pulse;
        default: p = 1'b0;
      endcase
      n_stat = m_stat;
      if (m_tick) n_stat = 1'b1;
      if (wr_en && wr_sel && wr_be[0]) n_stat = 1'b0;
      m_pin  = m_pen && p;
      m_tick = w;
      m_cnt  = n_cnt;
      m_stat = n_stat;
      if (wr_en && !wr_sel) begin
        if (wr_be[0]) m_cal = wr_data[7:0];
        if (wr_be[1]) begin
          m_pen = wr_data[14];
          m_src = wr_data[13:12];
          if (wr_unlock) m_run = wr_data[15];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check(cfg_rdata == exp_word(), {cur_req, " cfg"}, cfg_rdata, exp_word());
      check(sec_tick == m_tick, {cur_req, " tick"}, sec_tick, m_tick);
      check(rtc_pin == m_pin, {cur_req, " pin"}, rtc_pin, m_pin);
    end
  end

  task automatic step();
    @(negedge clk);
    alarm_pulse = (($urandom % 5) == 0);
    sec_phase++;
    if (sec_phase == 23) begin sec_phase = 0; sec_clk = ~sec_clk; end
  endtask

  task automatic idle_inputs();
    rtc_pulse = 0; min_strobe = 0; wr_en = 0; wr_sel = 0; wr_be = 0;
    wr_data = 0; wr_unlock = 0;
  endtask

  task automatic write(input bit sel, input bit [1:0] be, input bit [15:0] d, input bit unl);
    wr_en = 1; wr_sel = sel; wr_be = be; wr_data = d; wr_unlock = unl;
    step();
    wr_en = 0; wr_be = 0; wr_unlock = 0;
  endtask

  task automatic do_por();
    chk_on = 0; mdl_run = 0;
    idle_inputs();
    por_n = 0;
    m_run = 0; m_pen = 0; m_src = 0; m_stat = 0; m_cal = 0; m_cnt = 0; m_tick = 0; m_pin = 0;
    repeat (3) step();
    cur_req = "R1";
    check(cfg_rdata == 16'h0000, "R1 cfg after por", cfg_rdata, 0);
    check(sec_tick == 1'b0, "R1 tick after por", sec_tick, 0);
    check(rtc_pin == 1'b0, "R1 pin after por", rtc_pin, 0);
    por_n = 1;
    repeat (4) step();
    mdl_run = 1; chk_on = 1;
  endtask

  // measure pulses from an aligned minute load to the 8th following tick
  task automatic measure(input bit [7:0] code, input bit [1:0] src);
    int np, nt;
    bit first;
    cur_req = "R4";
    write(1'b0, 2'b11, {3'b110, src[0], 4'b0000, code}, 1'b1);
    if (src[1]) write(1'b0, 2'b10, {2'b11, src, 12'h000}, 1'b1);
    rtc_pulse = 1;
    while (m_cnt != P - 1) step();
    cur_req = "R3";
    min_strobe = 1;
    step();
    min_strobe = 0;
    check(sec_tick == 1'b1, "R3 wrap tick kept with minute load", sec_tick, 1);
    cur_req = "R4";
    np = 0; nt = 0; first = 1;
    while (nt < 8) begin
      if (sec_tick && !first) nt++;
      first = 0;
      if (nt < 8) begin np++; step(); end
    end
    check(np == 8 * P - 4 * int'($signed(code)), "R4 pulses over corrected window",
          np, 8 * P - 4 * int'($signed(code)));
    rtc_pulse = 0;
  endtask

  initial begin
    bit [15:0] saved;
    int seen;
    sys_rst_n = 1; sec_clk = 0; alarm_pulse = 0;
    do_por();

    // byte enables, lock and unimplemented bits
    cur_req = "R12";
    write(1'b0, 2'b01, 16'hFFFF, 1'b0);
    cur_req = "R6";
    write(1'b0, 2'b10, 16'hFFFF, 1'b0);
    step();
    check(cfg_rdata == 16'h70FF, "R6 R7 R12 locked enable, masked bits", cfg_rdata, 16'h70FF);

    // run with sparse pulses, raw clock on pin
    cur_req = "R2";
    write(1'b0, 2'b11, 16'hE000, 1'b1);
    check(cfg_rdata[15] == 1'b1, "R6 enable written while unlocked", cfg_rdata[15], 1);
    for (int i = 0; i < 2500; i++) begin
      rtc_pulse = (($urandom % 3) != 0);
      step();
    end
    rtc_pulse = 0;

    // unaligned minute strobe with a nonzero trim
    cur_req = "R3";
    write(1'b0, 2'b01, 16'h0010, 1'b0);
    rtc_pulse = 1;
    repeat (100) step();
    min_strobe = 1; step(); min_strobe = 0;
    repeat (600) step();
    rtc_pulse = 0;

    measure(8'h00, 2'b01);
    measure(8'h01, 2'b00);
    measure(8'h7F, 2'b10);
    measure(8'hFF, 2'b11);
    measure(8'h80, 2'b01);

    // status set/clear collision
    cur_req = "R8";
    check(cfg_rdata[11] == 1'b1, "R8 status set by ticks", cfg_rdata[11], 1);
    write(1'b0, 2'b10, 16'h0800 | {cfg_rdata[15:12], 12'h000}, 1'b1);
    write(1'b1, 2'b10, 16'hFFFF, 1'b0);
    check(cfg_rdata[11] == 1'b1, "R8 high-byte minsec write keeps status", cfg_rdata[11], 1);
    rtc_pulse = 1;
    while (!(m_tick)) step();
    write(1'b1, 2'b01, 16'h0000, 1'b0);
    check(cfg_rdata[11] == 1'b0, "R8 clear wins over set", cfg_rdata[11], 0);

    // disabled prescaler
    cur_req = "R5";
    write(1'b0, 2'b10, 16'h6000, 1'b1);
    seen = 0;
    for (int i = 0; i < 1200; i++) begin
      min_strobe = (i == 300);
      step();
      if (sec_tick) seen++;
    end
    min_strobe = 0;
    check(seen == 0, "R5 no tick while disabled", seen, 0);

    // pin disabled with raw source
    cur_req = "R10";
    write(1'b0, 2'b10, 16'hA000, 1'b1);
    seen = 0;
    for (int i = 0; i < 700; i++) begin step(); if (rtc_pin) seen++; end
    check(seen == 0, "R10 pin held low", seen, 0);

    // reserved pin source
    cur_req = "R9";
    write(1'b0, 2'b10, 16'hF000, 1'b1);
    seen = 0;
    for (int i = 0; i < 300; i++) begin step(); if (rtc_pin) seen++; end
    check(seen == 0, "R9 reserved source low", seen, 0);
    write(1'b0, 2'b10, 16'hE000, 1'b1);
    repeat (300) step();

    // system reset keeps configuration
    cur_req = "R11";
    saved = cfg_rdata;
    chk_on = 0; mdl_run = 0;
    rtc_pulse = 0;
    sys_rst_n = 0;
    m_cnt = 0; m_tick = 0; m_pin = 0;
    repeat (3) step();
    check(sec_tick == 1'b0 && rtc_pin == 1'b0, "R11 outputs cleared", {sec_tick, rtc_pin}, 0);
    check(cfg_rdata == saved, "R11 cfg retained", cfg_rdata, saved);
    sys_rst_n = 1;
    repeat (4) step();
    mdl_run = 1; chk_on = 1;
    rtc_pulse = 1;
    repeat (P + 20) step();
    rtc_pulse = 0;

    do_por();
    step();

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule